// File: doc/BRIEF.md
# PHY link bring-up sequencer

This block walks an Ethernet PHY from power-up to a known link mode over a separate MDIO master. A start pulse pulls the PHY reset pin low and then releases it, both for a set number of millisecond ticks. The block then issues a soft reset through control register 0 and polls until the reset bit clears. It reads the two identifier registers. It then either enables auto-negotiation and polls for completion, or writes a fixed speed and duplex and waits a short settling time. Last, it resolves the link mode and samples the link status bit.

The link mode comes from a vendor-specific status register, which is read only when the identifier matches an expected value under a mask. A mismatch, or a field value with no mapping, yields the code for negotiation failure, and that code is treated as full duplex. Each bounded poll that runs out sets a timeout flag, and the sequence carries on, so it always reaches its done state. The block never configures a MAC and never generates MDIO bit timing.

Top module: `phy_linkup_seq`

## Requirements
- R1: A start pulse is accepted only in the idle or done state. The PHY reset output then goes low for RST_LOW_MS millisecond ticks, then high for RST_HIGH_MS ticks. Only after that does the first MDIO access begin, and no access is requested while the reset output is low.
- R2: The first access writes 0x8000 to register 0. Register 0 is then read until bit 15 reads 0, with at most RST_POLL_MAX reads. If the last allowed read still shows bit 15 set, timeout_o is set and the sequence continues.
- R3: phy_id_o equals register 2 in bits 31:16 and register 3 in bits 15:0.
- R4: With force_i low at start, register 0 is written with 0x1000. Register 1 is then read until bit 5 is set, with at most AN_POLL_MAX reads and one millisecond tick waited between reads. If the limit runs out, timeout_o is set and the sequence continues.
- R5: With force_i high at start, register 0 is written with speed_i in bit 13, duplex_i in bit 8 and all other bits 0. No further access starts for at least FORCE_WAIT_CYC clocks.
- R6: If (phy_id & 0xFFFFFFF0) equals 0x0007C0F0, register 31 is read once and its bits 4:2 are decoded. 001 gives code 1 (10M half), 101 gives 2 (10M full), 010 gives 3 (100M half), 110 gives 4 (100M full), and any other value gives 0 (failed). On a mismatch, register 31 is not read and the code is 0.
- R7: full_duplex_o is 1 for link codes 0, 2 and 4, and 0 for codes 1 and 3.
- R8: The final access reads register 1, and link_up_o takes its bit 2.
- R9: mdio_req_o stays high with stable register, direction and write data until mdio_done_i pulses. Each access is carried out exactly once. Only register 0 is ever written.
- R10: done_o rises after the final access. It stays high with the results held until the next accepted start, and it is low in the cycle after that start. A start while the sequence runs has no effect.
- R11: An accepted start clears timeout_o, so a run without exhausted polls reports no timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a bring-up run |
| force_i | input | 1 | 1 forces speed/duplex, 0 uses auto-negotiation |
| speed_i | input | 1 | Forced speed, 1 means 100M |
| duplex_i | input | 1 | Forced duplex, 1 means full |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| mdio_req_o | output | 1 | Access request to the MDIO master |
| mdio_wr_o | output | 1 | 1 for a write access |
| mdio_reg_o | output | 5 | PHY register address |
| mdio_wdata_o | output | 16 | Write data |
| mdio_done_i | input | 1 | Access complete pulse |
| mdio_rdata_i | input | 16 | Read data, valid with mdio_done_i |
| phy_rst_no | output | 1 | PHY reset pin, active low |
| link_mode_o | output | 3 | Resolved link code (see R6) |
| full_duplex_o | output | 1 | Duplex for the MAC |
| link_up_o | output | 1 | Link status |
| phy_id_o | output | 32 | PHY identifier |
| done_o | output | 1 | Sequence finished |
| timeout_o | output | 1 | A poll limit was exhausted |

## Verification
The bench counts millisecond ticks in each reset phase. A timer that reloads on a start issued mid-run, or that runs one tick off, shows up as a wrong count. Both poll limits are driven just below and exactly at exhaustion: an off-by-one counter either flags a timeout on a run that completed or takes one read too many. Identifiers that differ only in the masked revision nibble, or in bit 4 just above it, show whether the register 31 read and the decode are gated correctly. Unmapped field values and back-to-back runs show whether failure codes, duplex and the cleared timeout are reported correctly.

// File: rtl/phy_linkup_pkg.sv
package phy_linkup_pkg;

  typedef enum logic [2:0] {
    LM_FAIL     = 3'd0,
    LM_10_HALF  = 3'd1,
    LM_10_FULL  = 3'd2,
    LM_100_HALF = 3'd3,
    LM_100_FULL = 3'd4
  } link_mode_e;

  typedef enum logic [3:0] {
    S_IDLE, S_RST_LOW, S_RST_HIGH, S_SRST_WR, S_SRST_RD, S_ID_HI, S_ID_LO,
    S_CFG_WR, S_AN_RD, S_AN_WAIT, S_FWAIT, S_MODE_SEL, S_MODE_RD, S_LINK_RD,
    S_DONE
  } seq_state_e;

  localparam logic [4:0] REG_CTRL  = 5'd0;
  localparam logic [4:0] REG_STAT  = 5'd1;
  localparam logic [4:0] REG_ID_HI = 5'd2;
  localparam logic [4:0] REG_ID_LO = 5'd3;
  localparam logic [4:0] REG_VSTAT = 5'd31;

  localparam int CTRL_SRST_BIT  = 15;
  localparam int CTRL_SPEED_BIT = 13;
  localparam int CTRL_AN_BIT    = 12;
  localparam int CTRL_DUP_BIT   = 8;
  localparam int STAT_AN_BIT    = 5;
  localparam int STAT_LINK_BIT  = 2;

endpackage

// File: rtl/linkup_wait_timer.sv
module linkup_wait_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         dec_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/linkup_poll_cnt.sv
module linkup_poll_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  // current read is the limit-th one
  assign last_o = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i};
endmodule

// File: rtl/linkup_mode_decode.sv
module linkup_mode_decode
  import phy_linkup_pkg::*;
#(
  parameter logic [31:0] ID_MASK  = 32'hFFFF_FFF0,
  parameter logic [31:0] ID_VALUE = 32'h0007_C0F0
) (
  input  logic [31:0] phy_id_i,
  input  logic [2:0]  field_i,
  output logic        id_match_o,
  output link_mode_e  mode_o,
  output logic        full_duplex_o
);
  assign id_match_o = ((phy_id_i & ID_MASK) == ID_VALUE);

  always_comb begin
    mode_o = LM_FAIL;
    if (id_match_o) begin
      case (field_i)
        3'b001:  mode_o = LM_10_HALF;
        3'b101:  mode_o = LM_10_FULL;
        3'b010:  mode_o = LM_100_HALF;
        3'b110:  mode_o = LM_100_FULL;
        default: mode_o = LM_FAIL;
      endcase
    end
  end

  assign full_duplex_o = (mode_o != LM_10_HALF) && (mode_o != LM_100_HALF);
endmodule

// File: rtl/phy_linkup_seq.sv
module phy_linkup_seq
  import phy_linkup_pkg::*;
#(
  parameter int          RST_LOW_MS     = 25,
  parameter int          RST_HIGH_MS    = 10,
  parameter int          RST_POLL_MAX   = 10000,
  parameter int          AN_POLL_MAX    = 1000,
  parameter int          FORCE_WAIT_CYC = 5000,
  parameter logic [31:0] ID_MASK        = 32'hFFFF_FFF0,
  parameter logic [31:0] ID_VALUE       = 32'h0007_C0F0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        force_i,
  input  logic        speed_i,
  input  logic        duplex_i,
  input  logic        ms_tick_i,
  output logic        mdio_req_o,
  output logic        mdio_wr_o,
  output logic [4:0]  mdio_reg_o,
  output logic [15:0] mdio_wdata_o,
  input  logic        mdio_done_i,
  input  logic [15:0] mdio_rdata_i,
  output logic        phy_rst_no,
  output logic [2:0]  link_mode_o,
  output logic        full_duplex_o,
  output logic        link_up_o,
  output logic [31:0] phy_id_o,
  output logic        done_o,
  output logic        timeout_o
);
  localparam int MS_MAX   = (RST_LOW_MS > RST_HIGH_MS) ? RST_LOW_MS : RST_HIGH_MS;
  localparam int TMR_MAX  = (MS_MAX > FORCE_WAIT_CYC) ? MS_MAX : FORCE_WAIT_CYC;
  localparam int TMR_W    = $clog2(TMR_MAX + 1);
  localparam int POLL_MAX = (RST_POLL_MAX > AN_POLL_MAX) ? RST_POLL_MAX : AN_POLL_MAX;
  localparam int POLL_W   = $clog2(POLL_MAX + 1);

  seq_state_e        state_q, state_d;
  logic              tmr_load, tmr_dec, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              poll_clr, poll_inc, poll_last;
  logic [POLL_W-1:0] poll_lim;
  logic              force_q, speed_q, duplex_q;
  logic [31:0]       id_q;
  logic [2:0]        field_q;
  logic              link_q, tmo_q, prst_q, tmo_set;
  logic              id_match;
  link_mode_e        mode;
  logic              accept;

  assign accept = start_i && (state_q == S_IDLE || state_q == S_DONE);

  linkup_wait_timer #(.W(TMR_W)) u_timer (
    .clk_i, .rst_ni, .load_i(tmr_load), .load_val_i(tmr_val),
    .dec_i(tmr_dec), .zero_o(tmr_zero)
  );

  assign poll_lim = (state_q == S_AN_RD) ? POLL_W'(AN_POLL_MAX) : POLL_W'(RST_POLL_MAX);

  linkup_poll_cnt #(.W(POLL_W)) u_poll (
    .clk_i, .rst_ni, .clr_i(poll_clr), .inc_i(poll_inc),
    .limit_i(poll_lim), .last_o(poll_last)
  );

  linkup_mode_decode #(.ID_MASK(ID_MASK), .ID_VALUE(ID_VALUE)) u_dec (
    .phy_id_i(id_q), .field_i(field_q), .id_match_o(id_match),
    .mode_o(mode), .full_duplex_o(full_duplex_o)
  );

  assign tmr_dec = (state_q == S_RST_LOW || state_q == S_RST_HIGH) ? ms_tick_i
                                                                    : (state_q == S_FWAIT);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    poll_clr = 1'b0;
    poll_inc = 1'b0;
    tmo_set  = 1'b0;
    case (state_q)
      S_IDLE, S_DONE: if (start_i) begin
        state_d = S_RST_LOW; tmr_load = 1'b1; tmr_val = TMR_W'(RST_LOW_MS);
      end
      S_RST_LOW: if (tmr_zero) begin
        state_d = S_RST_HIGH; tmr_load = 1'b1; tmr_val = TMR_W'(RST_HIGH_MS);
      end
      S_RST_HIGH: if (tmr_zero) state_d = S_SRST_WR;
      S_SRST_WR: if (mdio_done_i) begin state_d = S_SRST_RD; poll_clr = 1'b1; end
      S_SRST_RD: if (mdio_done_i) begin
        if (!mdio_rdata_i[CTRL_SRST_BIT]) state_d = S_ID_HI;
        else if (poll_last) begin state_d = S_ID_HI; tmo_set = 1'b1; end
        else poll_inc = 1'b1;
      end
      S_ID_HI: if (mdio_done_i) state_d = S_ID_LO;
      S_ID_LO: if (mdio_done_i) state_d = S_CFG_WR;
      S_CFG_WR: if (mdio_done_i) begin
        if (force_q) begin
          state_d = S_FWAIT; tmr_load = 1'b1; tmr_val = TMR_W'(FORCE_WAIT_CYC);
        end else begin
          state_d = S_AN_RD; poll_clr = 1'b1;
        end
      end
      S_AN_RD: if (mdio_done_i) begin
        if (mdio_rdata_i[STAT_AN_BIT]) state_d = S_MODE_SEL;
        else if (poll_last) begin state_d = S_MODE_SEL; tmo_set = 1'b1; end
        else begin state_d = S_AN_WAIT; poll_inc = 1'b1; end
      end
      S_AN_WAIT:  if (ms_tick_i) state_d = S_AN_RD;
      S_FWAIT:    if (tmr_zero) state_d = S_MODE_SEL;
      S_MODE_SEL: state_d = id_match ? S_MODE_RD : S_LINK_RD;
      S_MODE_RD:  if (mdio_done_i) state_d = S_LINK_RD;
      S_LINK_RD:  if (mdio_done_i) state_d = S_DONE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_IDLE;
      force_q  <= 1'b0;
      speed_q  <= 1'b0;
      duplex_q <= 1'b0;
      id_q     <= '0;
      field_q  <= '0;
      link_q   <= 1'b0;
      tmo_q    <= 1'b0;
      prst_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        force_q  <= force_i;
        speed_q  <= speed_i;
        duplex_q <= duplex_i;
        id_q     <= '0;
        field_q  <= '0;
        link_q   <= 1'b0;
        tmo_q    <= 1'b0;
        prst_q   <= 1'b0;
      end
      if (state_q == S_RST_LOW && tmr_zero) prst_q <= 1'b1;
      if (tmo_set) tmo_q <= 1'b1;
      if (mdio_done_i) begin
        case (state_q)
          S_ID_HI:   id_q[31:16] <= mdio_rdata_i;
          S_ID_LO:   id_q[15:0]  <= mdio_rdata_i;
          S_MODE_RD: field_q     <= mdio_rdata_i[4:2];
          S_LINK_RD: link_q      <= mdio_rdata_i[STAT_LINK_BIT];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    mdio_req_o   = 1'b1;
    mdio_wr_o    = 1'b0;
    mdio_reg_o   = REG_CTRL;
    mdio_wdata_o = '0;
    case (state_q)
      S_SRST_WR: begin
        mdio_wr_o = 1'b1;
        mdio_wdata_o[CTRL_SRST_BIT] = 1'b1;
      end
      S_SRST_RD: ;
      S_ID_HI:   mdio_reg_o = REG_ID_HI;
      S_ID_LO:   mdio_reg_o = REG_ID_LO;
      S_CFG_WR: begin
        mdio_wr_o = 1'b1;
        if (force_q) begin
          mdio_wdata_o[CTRL_SPEED_BIT] = speed_q;
          mdio_wdata_o[CTRL_DUP_BIT]   = duplex_q;
        end else begin
          mdio_wdata_o[CTRL_AN_BIT] = 1'b1;
        end
      end
      S_AN_RD, S_LINK_RD: mdio_reg_o = REG_STAT;
      S_MODE_RD:          mdio_reg_o = REG_VSTAT;
      default:            mdio_req_o = 1'b0;
    endcase
  end

  assign phy_rst_no  = prst_q;
  assign link_mode_o = mode;
  assign link_up_o   = link_q;
  assign phy_id_o    = id_q;
  assign done_o      = (state_q == S_DONE);
  assign timeout_o   = tmo_q;
endmodule

// File: rtl/phy_linkup_seq_chk.sv
module phy_linkup_seq_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        start_i,
  input logic        phy_rst_no,
  input logic        mdio_req_o,
  input logic        mdio_wr_o,
  input logic [4:0]  mdio_reg_o,
  input logic [15:0] mdio_wdata_o,
  input logic        mdio_done_i,
  input logic        done_o,
  input logic        timeout_o,
  input logic [2:0]  link_mode_o,
  input logic        full_duplex_o
);
  // R1
  no_access_in_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phy_rst_no |-> !mdio_req_o);

  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_req_o && !mdio_done_i |=> mdio_req_o && $stable(mdio_reg_o)
      && $stable(mdio_wr_o) && $stable(mdio_wdata_o));

  // R9
  write_reg0_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdio_req_o && mdio_wr_o |-> mdio_reg_o == 5'd0);

  // R10
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(link_mode_o) && $stable(full_duplex_o)
      && $stable(timeout_o));

  // R6
  mode_code_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> link_mode_o <= 3'd4);

  // R11
  start_clears_tmo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && done_o |=> !timeout_o && !done_o);

  // R2
  tmo_before_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> !done_o);
endmodule

bind phy_linkup_seq phy_linkup_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .phy_rst_no(phy_rst_no),
  .mdio_req_o(mdio_req_o), .mdio_wr_o(mdio_wr_o), .mdio_reg_o(mdio_reg_o),
  .mdio_wdata_o(mdio_wdata_o), .mdio_done_i(mdio_done_i), .done_o(done_o),
  .timeout_o(timeout_o), .link_mode_o(link_mode_o), .full_duplex_o(full_duplex_o)
);

// File: tb/phy_linkup_seq_test.sv
`timescale 1ns/1ps
module phy_linkup_seq_test;
  localparam int LOW_MS = 25, HIGH_MS = 10, RPM = 4, APM = 3, FWC = 20, TP = 10;

  typedef struct packed {
    logic        frc, spd, dup;
    logic [31:0] id;
    logic [3:0]  srst, an;
    logic [2:0]  fld;
    logic        lnk;
    logic [2:0]  e_mode;
    logic        e_fd;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,32'h0007C0F1,4'd2,4'd1,3'b110,1'b1,3'd4,1'b1},
    '{1'b0,1'b0,1'b0,32'h0007C0FF,4'd0,4'd0,3'b101,1'b0,3'd2,1'b1},
    '{1'b1,1'b1,1'b0,32'h0007C0F3,4'd1,4'd0,3'b010,1'b1,3'd3,1'b0},
    '{1'b1,1'b0,1'b1,32'h0007C0F0,4'd0,4'd0,3'b001,1'b1,3'd1,1'b0},
    '{1'b0,1'b0,1'b0,32'h00221560,4'd1,4'd1,3'b110,1'b1,3'd0,1'b1},
    '{1'b0,1'b0,1'b0,32'h0007C0F2,4'd0,4'd0,3'b011,1'b1,3'd0,1'b1},
    '{1'b0,1'b0,1'b0,32'h0007C0F4,4'd5,4'd0,3'b110,1'b1,3'd4,1'b1},
    '{1'b0,1'b0,1'b0,32'h0007C0F5,4'd3,4'd2,3'b001,1'b0,3'd1,1'b0},
    '{1'b0,1'b0,1'b0,32'h0007C0F6,4'd0,4'd3,3'b101,1'b0,3'd2,1'b1},
    '{1'b1,1'b1,1'b1,32'h0007C0E0,4'd0,4'd0,3'b110,1'b1,3'd0,1'b1},
    '{1'b0,1'b0,1'b0,32'h0007C0F7,4'd0,4'd0,3'b111,1'b1,3'd0,1'b1}
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, force_i = 1'b0, speed_i = 1'b0, duplex_i = 1'b0, ms_tick_i = 1'b0;
  logic mdio_done_i = 1'b0;
  logic [15:0] mdio_rdata_i = '0;
  logic mdio_req_o, mdio_wr_o, phy_rst_no, full_duplex_o, link_up_o, done_o, timeout_o;
  logic [4:0] mdio_reg_o;
  logic [15:0] mdio_wdata_o;
  logic [2:0] link_mode_o;
  logic [31:0] phy_id_o;

  always #10 clk = ~clk;

  phy_linkup_seq #(
    .RST_LOW_MS(LOW_MS), .RST_HIGH_MS(HIGH_MS), .RST_POLL_MAX(RPM),
    .AN_POLL_MAX(APM), .FORCE_WAIT_CYC(FWC)
  ) uut (
    .clk_i(clk), .rst_ni, .start_i, .force_i, .speed_i, .duplex_i, .ms_tick_i,
    .mdio_req_o, .mdio_wr_o, .mdio_reg_o, .mdio_wdata_o, .mdio_done_i, .mdio_rdata_i,
    .phy_rst_no, .link_mode_o, .full_duplex_o, .link_up_o, .phy_id_o, .done_o, .timeout_o
  );

  int n_chk = 0, n_bad = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // PHY model state
  logic [31:0] m_id = '0;
  logic [2:0]  m_fld = '0;
  logic        m_lnk = 1'b0;
  int m_srst_left = 0, m_an_left = 0, m_srst_set = 0;
  int n_r0 = 0, n_r1 = 0, n_r31 = 0, n_srst_wr = 0, n_cfg = 0, gap = -1;
  logic [15:0] cfg_val = '0;
  int m_cyc = 0, cfg_cyc = 0, lat = 0;
  bit busy = 0, want_gap = 0;
  logic [4:0] a_reg = '0;
  logic a_wr = 1'b0;
  logic [15:0] a_wd = '0;

  always @(negedge clk) begin
    m_cyc++;
    if (mdio_done_i) mdio_done_i = 1'b0;
    else if (busy) begin
      if (lat > 0) lat--;
      else begin
        busy = 0;
        mdio_done_i = 1'b1;
        mdio_rdata_i = 16'hFFFF;
        if (a_wr) begin
          if (a_reg == 5'd0 && a_wd == 16'h8000) begin
            n_srst_wr++; m_srst_left = m_srst_set;
          end else begin
            n_cfg++; cfg_val = a_wd; cfg_cyc = m_cyc; want_gap = 1;
          end
        end else begin
          case (a_reg)
            5'd0: begin
              n_r0++;
              mdio_rdata_i = 16'h1140;
              if (m_srst_left > 0) begin mdio_rdata_i[15] = 1'b1; m_srst_left--; end
            end
            5'd1: begin
              n_r1++;
              mdio_rdata_i = 16'h7809;
              mdio_rdata_i[2] = m_lnk;
              if (m_an_left > 0) begin mdio_rdata_i[5] = 1'b0; m_an_left--; end
              else mdio_rdata_i[5] = 1'b1;
            end
            5'd2:  mdio_rdata_i = m_id[31:16];
            5'd3:  mdio_rdata_i = m_id[15:0];
            5'd31: begin n_r31++; mdio_rdata_i = 16'hA0E3; mdio_rdata_i[4:2] = m_fld; end
            default: ;
          endcase
        end
      end
    end else if (mdio_req_o) begin
      busy = 1; lat = 2; a_reg = mdio_reg_o; a_wr = mdio_wr_o; a_wd = mdio_wdata_o;
      if (want_gap) begin gap = m_cyc - cfg_cyc; want_gap = 0; end
    end
  end

  // stimulus stepping and tick accounting, single process
  int tick_ph = 0, lo_ticks = 0, hi_ticks = 0;
  bit rst_prev = 0, req_seen = 0, done_prev = 0, first_run = 1;

  task automatic cyc();
    @(negedge clk);
    if (start_i && (done_prev || first_run)) begin
      lo_ticks = 0; hi_ticks = 0; req_seen = 0; first_run = 0;
    end else if (ms_tick_i) begin
      if (!rst_prev) lo_ticks++;
      else if (!req_seen) hi_ticks++;
    end
    rst_prev = phy_rst_no;
    done_prev = done_o;
    if (mdio_req_o) req_seen = 1;
    tick_ph = (tick_ph + 1) % TP;
    ms_tick_i = (tick_ph == 0);
    start_i = 1'b0;
  endtask

  task automatic run_vec(input int i, input bit poke);
    vec_t v;
    int exp_r0, exp_r1, exp_r31;
    bit exp_to, match;
    logic [15:0] exp_cfg;
    v = VECS[i];
    m_id = v.id; m_fld = v.fld; m_lnk = v.lnk;
    m_srst_set = int'(v.srst); m_an_left = int'(v.an); m_srst_left = 0;
    n_r0 = 0; n_r1 = 0; n_r31 = 0; n_srst_wr = 0; n_cfg = 0; gap = -1; want_gap = 0;
    force_i = v.frc; speed_i = v.spd; duplex_i = v.dup;
    while (ms_tick_i) cyc();
    start_i = 1'b1;
    cyc();
    // R10
    chk(done_o == 1'b0, "R10", $sformatf("vec%0d done after start", i), done_o, 0);
    for (int c = 0; c < 4000 && !done_o; c++) begin
      if (poke && c == 100) start_i = 1'b1;
      cyc();
    end
    exp_r0  = (int'(v.srst) + 1 > RPM) ? RPM : int'(v.srst) + 1;
    exp_to  = (int'(v.srst) >= RPM) || (!v.frc && int'(v.an) >= APM);
    exp_r1  = v.frc ? 1 : (((int'(v.an) + 1 > APM) ? APM : int'(v.an) + 1) + 1);
    match   = ((v.id & 32'hFFFF_FFF0) == 32'h0007_C0F0);
    exp_r31 = match ? 1 : 0;
    exp_cfg = v.frc ? ((16'(v.spd) << 13) | (16'(v.dup) << 8)) : 16'h1000;
    chk(done_o == 1'b1, "R10", $sformatf("vec%0d done", i), done_o, 1);
    chk(lo_ticks == LOW_MS, "R1", $sformatf("vec%0d low ticks", i), lo_ticks, LOW_MS);
    chk(hi_ticks == HIGH_MS, "R1", $sformatf("vec%0d high ticks", i), hi_ticks, HIGH_MS);
    chk(n_srst_wr == 1, "R9", $sformatf("vec%0d soft reset writes", i), n_srst_wr, 1);
    chk(n_r0 == exp_r0, "R2", $sformatf("vec%0d reg0 polls", i), n_r0, exp_r0);
    chk(timeout_o == exp_to, "R2/R4/R11", $sformatf("vec%0d timeout", i), timeout_o, exp_to);
    chk(phy_id_o == v.id, "R3", $sformatf("vec%0d phy id", i), phy_id_o, v.id);
    chk(n_cfg == 1, "R9", $sformatf("vec%0d config writes", i), n_cfg, 1);
    chk(cfg_val == exp_cfg, v.frc ? "R5" : "R4", $sformatf("vec%0d config word", i),
        cfg_val, exp_cfg);
    chk(n_r1 == exp_r1, "R4", $sformatf("vec%0d reg1 reads", i), n_r1, exp_r1);
    if (v.frc)
      chk(gap >= FWC && gap <= FWC + 4, "R5", $sformatf("vec%0d settle gap", i), gap, FWC);
    chk(n_r31 == exp_r31, "R6", $sformatf("vec%0d reg31 reads", i), n_r31, exp_r31);
    chk(link_mode_o == v.e_mode, "R6", $sformatf("vec%0d link mode", i), link_mode_o, v.e_mode);
    chk(full_duplex_o == v.e_fd, "R7", $sformatf("vec%0d duplex", i), full_duplex_o, v.e_fd);
    chk(link_up_o == v.lnk, "R8", $sformatf("vec%0d link up", i), link_up_o, v.lnk);
    for (int c = 0; c < 5; c++) cyc();
    chk(done_o && link_mode_o == v.e_mode, "R10", $sformatf("vec%0d hold", i),
        link_mode_o, v.e_mode);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk(phy_rst_no == 1'b0, "R1", "reset pin in reset", phy_rst_no, 0);
    chk(mdio_req_o == 1'b0, "R9", "req in reset", mdio_req_o, 0);
    rst_ni = 1'b1;
    repeat (3) cyc();
    chk(done_o == 1'b0 && timeout_o == 1'b0, "R10", "idle flags", {done_o, timeout_o}, 0);
    chk(phy_rst_no == 1'b0 && mdio_req_o == 1'b0, "R1", "idle outputs",
        {phy_rst_no, mdio_req_o}, 0);
    for (int i = 0; i < NV; i++) run_vec(i, 1'b0);
    // start pulse mid-run must not restart the reset phase
    run_vec(0, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule